// File: doc/BRIEF.md
# Prioritized Trigger Delay Counter Group

The block collects trigger flags raised by timer channels and turns each of them into a delayed conversion request. The flags are split into groups of equal size. Each group owns one delay down-counter. When the group's counter is free and at least one of its flags is high, the group accepts the lowest-numbered flag. It loads the counter from one of four shared start-value registers, chosen by that source's delay-select field, and sends the source a one-cycle acknowledge so the source can drop its flag. Any flag that loses this selection stays high and is served once the counter is free again.

When a group's counter reaches zero, the group holds a request together with the channel number configured for the accepted source. A second, fixed-priority arbiter takes the lowest-numbered group that holds a request and issues a one-cycle trigger with that channel number. Groups that lose wait until they are granted. Some sources are marked at build time as periodic-timer inputs. On those sources a per-source force bit holds the acknowledge high, so software can clear the timer flag.

Configuration is written through a single-cycle write strobe with an address and a data word. There is no read path.

Top module: `prio_trig_delay`

## Requirements
- R1: A write with address 0 to 3 loads the 16-bit start-value register of that index. A write with address 4+s configures source s, using data bits [1:0] as the delay select (the start-value index), bits [6:2] as the channel number and bit 7 as the force bit. A write takes effect on the clock edge that samples the strobe.
- R2: A group that is idle in cycle c and sees a flag accepts it at the end of c and loads its counter with the selected start value S. The matching trigger is high in cycle c+S+3.
- R3: The accepted source, and only that source, receives an acknowledge that is high for exactly one cycle: the cycle after acceptance.
- R4: When several flags of one group are high in an idle cycle, the lowest source index is accepted. The others stay pending and are accepted, again lowest first, in the first idle cycle after the trigger is issued.
- R5: The counter steps down by one per clock. A start value of 0 gives the shortest path, with the trigger three cycles after the flag is seen.
- R6: The trigger output is high for one cycle per granted request. In that cycle the channel output carries the channel number configured for the accepted source.
- R7: On a source marked force-capable (by default only source 7), a set force bit drives that source's acknowledge high for as long as the bit is set.
- R8: On a source not marked force-capable, the force bit has no effect on its acknowledge.
- R9: When several groups hold an expired request in the same cycle, the lowest group index is granted first. Each other group keeps its request and is granted in a later cycle, one group per cycle.
- R10: A synchronous active-high reset clears the counters, the pending requests, every acknowledge, the trigger and all configuration.
- R11: A group that is counting or holding an expired request accepts no flag and sends no acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flag_i | input | 8 | Trigger flags from timer sources, source s on bit s, group g holds bits 4g..4g+3 |
| ack_o | output | 8 | Acknowledge back to each source |
| wr_en_i | input | 1 | Configuration write strobe |
| wr_addr_i | input | 4 | Configuration address |
| wr_data_i | input | 16 | Configuration write data |
| trig_o | output | 1 | One-cycle trigger toward the converter |
| chan_o | output | 5 | Channel number qualified by trig_o |

## Verification
Two groups can expire in the same cycle, and then cross-group arbitration and the return of the winning group to idle happen together. The bench provokes this by raising flags in both groups in one cycle, with both sources set to a zero start value. It then expects triggers in two consecutive cycles, lower group first, each with its own channel number. A second collision, a trigger issued in the same cycle that a pending loser of the same group is accepted, comes from raising two flags of one group at once. That case is judged by the twelve-cycle gap the bench computes between the two triggers. A behavioural reference model compares every acknowledge, trigger and channel on every cycle, including across a reset taken while a count is in progress.

// File: rtl/trig_delay_pkg.sv
package trig_delay_pkg;

    localparam int CNT_W     = 16;
    localparam int NUM_START = 4;
    localparam int SEL_W     = $clog2(NUM_START);
    localparam int CH_W      = 5;
    localparam int DATA_W    = 16;
    localparam int ROUTE_W   = SEL_W + CH_W;
    localparam int FRC_BIT   = ROUTE_W;

    typedef enum logic [1:0] {
        GRP_IDLE  = 2'd0,
        GRP_COUNT = 2'd1,
        GRP_HOLD  = 2'd2
    } grp_state_e;

    typedef struct packed {
        logic [CH_W-1:0]  chan;
        logic [SEL_W-1:0] dsel;
    } route_t;

    typedef struct packed {
        logic            valid;
        logic [CH_W-1:0] chan;
    } trig_t;

    function automatic route_t route_from_word(logic [ROUTE_W-1:0] w);
        route_t r;
        r.dsel = w[SEL_W-1:0];
        r.chan = w[ROUTE_W-1:SEL_W];
        return r;
    endfunction

endpackage

// File: rtl/tdc_cfg_regs.sv
module tdc_cfg_regs
    import trig_delay_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int ADDR_W  = 4,
    parameter logic [NUM_SRC-1:0] FORCE_MASK = '0
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              wr_en_i,
    input  logic [ADDR_W-1:0]                 wr_addr_i,
    input  logic [DATA_W-1:0]                 wr_data_i,
    output logic [NUM_START-1:0][CNT_W-1:0]   start_o,
    output route_t [NUM_SRC-1:0]              route_o,
    output logic [NUM_SRC-1:0]                frc_o
);

    logic [NUM_START-1:0][CNT_W-1:0] start_q;
    route_t [NUM_SRC-1:0]            route_q;
    logic [NUM_SRC-1:0]              frc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= '0;
        end else if (wr_en_i) begin
            for (int k = 0; k < NUM_START; k++) begin
                if (wr_addr_i == ADDR_W'(k)) begin
                    start_q[k] <= wr_data_i[CNT_W-1:0];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            route_q <= '0;
        end else if (wr_en_i) begin
            for (int s = 0; s < NUM_SRC; s++) begin
                if (wr_addr_i == ADDR_W'(NUM_START + s)) begin
                    route_q[s] <= route_from_word(wr_data_i[ROUTE_W-1:0]);
                end
            end
        end
    end

    // Force bits exist only on force-capable sources; others are tied low.
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_frc
        if (FORCE_MASK[s]) begin : g_cap
            always_ff @(posedge clk) begin
                if (rst) begin
                    frc_q[s] <= 1'b0;
                end else if (wr_en_i && wr_addr_i == ADDR_W'(NUM_START + s)) begin
                    frc_q[s] <= wr_data_i[FRC_BIT];
                end
            end
        end else begin : g_nocap
            assign frc_q[s] = 1'b0;
        end
    end

    assign start_o = start_q;
    assign route_o = route_q;
    assign frc_o   = frc_q;

endmodule

// File: rtl/tdc_group.sv
module tdc_group
    import trig_delay_pkg::*;
#(
    parameter int GW = 4
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [GW-1:0]                   flag_i,
    input  route_t [GW-1:0]                 route_i,
    input  logic [NUM_START-1:0][CNT_W-1:0] start_i,
    input  logic                            grant_i,
    output logic [GW-1:0]                   ack_o,
    output logic                            req_o,
    output logic [CH_W-1:0]                 chan_o
);

    localparam int IDX_W = (GW > 1) ? $clog2(GW) : 1;

    grp_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CH_W-1:0]  chan_q;
    logic [GW-1:0]    ack_q;
    logic [IDX_W-1:0] win_idx;
    logic             any_flag;

    // Lowest index wins: scan downwards so the last hit is the smallest.
    always_comb begin
        win_idx  = '0;
        any_flag = 1'b0;
        for (int i = GW - 1; i >= 0; i--) begin
            if (flag_i[i]) begin
                win_idx  = IDX_W'(i);
                any_flag = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= GRP_IDLE;
            cnt_q   <= '0;
            chan_q  <= '0;
            ack_q   <= '0;
        end else begin
            ack_q <= '0;
            case (state_q)
                GRP_IDLE: begin
                    if (any_flag) begin
                        state_q        <= GRP_COUNT;
                        cnt_q          <= start_i[route_i[win_idx].dsel];
                        chan_q         <= route_i[win_idx].chan;
                        ack_q[win_idx] <= 1'b1;
                    end
                end
                GRP_COUNT: begin
                    if (cnt_q == '0) begin
                        state_q <= GRP_HOLD;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                GRP_HOLD: begin
                    if (grant_i) begin
                        state_q <= GRP_IDLE;
                    end
                end
                default: state_q <= GRP_IDLE;
            endcase
        end
    end

    assign ack_o  = ack_q;
    assign req_o  = (state_q == GRP_HOLD);
    assign chan_o = chan_q;

    assert_ack_onehot_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ack_q));

    assert_ack_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        (|ack_q) |=> !(|ack_q));

    assert_lowest_wins_R4: assert property (@(posedge clk) disable iff (rst)
        (state_q == GRP_IDLE && flag_i[0]) |=> ack_q[0]);

    assert_count_step_R5: assert property (@(posedge clk) disable iff (rst)
        (state_q == GRP_COUNT && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

    assert_busy_no_ack_R11: assert property (@(posedge clk) disable iff (rst)
        (state_q != GRP_IDLE) |=> (state_q == GRP_IDLE || !(|ack_q) || $past(state_q) == GRP_IDLE));

endmodule

// File: rtl/tdc_trig_arb.sv
module tdc_trig_arb
    import trig_delay_pkg::*;
#(
    parameter int NG = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NG-1:0]            req_i,
    input  logic [NG-1:0][CH_W-1:0]  chan_i,
    output logic [NG-1:0]            grant_o,
    output logic                     trig_o,
    output logic [CH_W-1:0]          chan_o
);

    logic [NG-1:0]   grant;
    logic            found;
    logic [CH_W-1:0] sel_chan;
    trig_t           out_q;

    always_comb begin
        grant    = '0;
        found    = 1'b0;
        sel_chan = '0;
        for (int g = 0; g < NG; g++) begin
            if (req_i[g] && !found) begin
                grant[g] = 1'b1;
                found    = 1'b1;
                sel_chan = chan_i[g];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q.valid <= found;
            if (found) begin
                out_q.chan <= sel_chan;
            end
        end
    end

    assign grant_o = grant;
    assign trig_o  = out_q.valid;
    assign chan_o  = out_q.chan;

    assert_grant_onehot_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    assert_trig_from_req_R6: assert property (@(posedge clk) disable iff (rst)
        out_q.valid |-> $past(|req_i));

endmodule

// File: rtl/prio_trig_delay.sv
module prio_trig_delay
    import trig_delay_pkg::*;
#(
    parameter int NUM_GROUPS = 2,
    parameter int GROUP_SIZE = 4,
    parameter int ADDR_W     = $clog2(NUM_START + NUM_GROUPS * GROUP_SIZE),
    parameter logic [NUM_GROUPS*GROUP_SIZE-1:0] FORCE_MASK = 8'h80
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic [NUM_GROUPS*GROUP_SIZE-1:0]   flag_i,
    output logic [NUM_GROUPS*GROUP_SIZE-1:0]   ack_o,
    input  logic                               wr_en_i,
    input  logic [ADDR_W-1:0]                  wr_addr_i,
    input  logic [DATA_W-1:0]                  wr_data_i,
    output logic                               trig_o,
    output logic [CH_W-1:0]                    chan_o
);

    localparam int NUM_SRC = NUM_GROUPS * GROUP_SIZE;

    logic [NUM_START-1:0][CNT_W-1:0]  start_vals;
    route_t [NUM_SRC-1:0]             routes;
    logic [NUM_SRC-1:0]               frc_bits;
    logic [NUM_SRC-1:0]               grp_ack;
    logic [NUM_GROUPS-1:0]            grp_req;
    logic [NUM_GROUPS-1:0]            grp_grant;
    logic [NUM_GROUPS-1:0][CH_W-1:0]  grp_chan;

    tdc_cfg_regs #(
        .NUM_SRC    (NUM_SRC),
        .ADDR_W     (ADDR_W),
        .FORCE_MASK (FORCE_MASK)
    ) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .start_o   (start_vals),
        .route_o   (routes),
        .frc_o     (frc_bits)
    );

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        tdc_group #(
            .GW (GROUP_SIZE)
        ) u_grp (
            .clk     (clk),
            .rst     (rst),
            .flag_i  (flag_i[g*GROUP_SIZE +: GROUP_SIZE]),
            .route_i (routes[g*GROUP_SIZE +: GROUP_SIZE]),
            .start_i (start_vals),
            .grant_i (grp_grant[g]),
            .ack_o   (grp_ack[g*GROUP_SIZE +: GROUP_SIZE]),
            .req_o   (grp_req[g]),
            .chan_o  (grp_chan[g])
        );
    end

    tdc_trig_arb #(
        .NG (NUM_GROUPS)
    ) u_arb (
        .clk     (clk),
        .rst     (rst),
        .req_i   (grp_req),
        .chan_i  (grp_chan),
        .grant_o (grp_grant),
        .trig_o  (trig_o),
        .chan_o  (chan_o)
    );

    // Force bits are tied low on sources that are not force-capable.
    assign ack_o = grp_ack | frc_bits;

endmodule

// File: tb/tb_prio_trig_delay.sv
`timescale 1ns/1ps
module tb_prio_trig_delay;

    localparam int G  = 2;
    localparam int GW = 4;
    localparam int N  = G * GW;
    localparam int AW = 4;
    localparam logic [N-1:0] FMASK = 8'h80;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  flags = '0;
    logic [N-1:0]  ack;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [15:0]   wr_data = '0;
    logic          trig;
    logic [4:0]    chan;

    always #2 clk = ~clk;   // 250 MHz

    prio_trig_delay dut (
        .clk       (clk),
        .rst       (rst),
        .flag_i    (flags),
        .ack_o     (ack),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .trig_o    (trig),
        .chan_o    (chan)
    );

    int n_tests = 0;
    int n_fail  = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_state [G];    // 0 idle, 1 counting, 2 holding
    int m_cnt   [G];
    int m_ch    [G];
    bit m_ack   [N];
    bit m_trig;
    int m_chan;
    int m_start [4];
    int m_dsel  [N];
    int m_chf   [N];
    bit m_frc   [N];

    always @(posedge clk) begin
        int gw;
        int w;
        if (rst) begin
            for (int g = 0; g < G; g++) begin m_state[g] = 0; m_cnt[g] = 0; m_ch[g] = 0; end
            for (int i = 0; i < N; i++) begin m_ack[i] = 0; m_dsel[i] = 0; m_chf[i] = 0; m_frc[i] = 0; end
            for (int k = 0; k < 4; k++) m_start[k] = 0;
            m_trig = 0;
            m_chan = 0;
        end else begin
            gw = -1;
            for (int g = 0; g < G; g++) if (m_state[g] == 2 && gw < 0) gw = g;
            m_trig = (gw >= 0);
            if (gw >= 0) m_chan = m_ch[gw];
            for (int i = 0; i < N; i++) m_ack[i] = 0;
            for (int g = 0; g < G; g++) begin
                if (m_state[g] == 0) begin
                    w = -1;
                    for (int i = 0; i < GW; i++) if (flags[g*GW+i] && w < 0) w = g*GW + i;
                    if (w >= 0) begin
                        m_state[g] = 1;
                        m_cnt[g]   = m_start[m_dsel[w]];
                        m_ch[g]    = m_chf[w];
                        m_ack[w]   = 1;
                    end
                end else if (m_state[g] == 1) begin
                    if (m_cnt[g] == 0) m_state[g] = 2;
                    else m_cnt[g] = m_cnt[g] - 1;
                end else begin
                    if (gw == g) m_state[g] = 0;
                end
            end
            if (wr_en) begin
                if (wr_addr < 4) m_start[wr_addr] = wr_data;
                else if (int'(wr_addr) - 4 < N) begin
                    m_dsel[wr_addr-4] = wr_data[1:0];
                    m_chf[wr_addr-4]  = wr_data[6:2];
                    m_frc[wr_addr-4]  = wr_data[7];
                end
            end
        end
    end

    // One cycle: compare at the falling edge, then act as the sources and the writer.
    task automatic cyc(input logic [N-1:0] raise, input bit we = 0,
                       input logic [AW-1:0] a = '0, input logic [15:0] d = '0);
        @(negedge clk);
        if (!rst) begin
            for (int i = 0; i < N; i++) begin
                bit e;
                e = m_ack[i] | (m_frc[i] & FMASK[i]);
                chk(ack[i] == e, "R3 ack vs model", int'(ack[i]), int'(e));
            end
            chk(trig == m_trig, "R6 trigger vs model", int'(trig), int'(m_trig));
            if (m_trig) chk(chan == 5'(m_chan), "R6 channel vs model", int'(chan), m_chan);
        end
        flags   = (flags & ~ack) | raise;
        wr_en   = we;
        wr_addr = a;
        wr_data = d;
    endtask

    task automatic wait_trig(input int exp_k, input int exp_ch, input string req);
        int k;
        k = 0;
        for (int t = 0; t < 100; t++) begin
            cyc('0);
            k++;
            if (trig) break;
        end
        chk(k == exp_k, {req, " trigger latency"}, k, exp_k);
        chk(chan == 5'(exp_ch), {req, " trigger channel"}, int'(chan), exp_ch);
    endtask

    function automatic logic [15:0] cfg_word(input int ch, input int ds, input bit f);
        return 16'((int'(f) << 7) | (ch << 2) | ds);
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        int seen;
        repeat (3) @(negedge clk);
        chk(ack == '0, "R10 ack in reset", int'(ack), 0);
        chk(trig == 1'b0, "R10 trigger in reset", int'(trig), 0);
        rst = 1'b0;

        // R1: start values 0,5,2,9; source s: channel 10+s, delay select s%4
        cyc('0, 1, 4'd0, 16'd0);
        cyc('0, 1, 4'd1, 16'd5);
        cyc('0, 1, 4'd2, 16'd2);
        cyc('0, 1, 4'd3, 16'd9);
        for (int s = 0; s < N; s++) cyc('0, 1, AW'(4 + s), cfg_word(10 + s, s % 4, 0));
        cyc('0);

        // R1 R2: source 1 uses start 5 -> trigger S+3 = 8 cycles later
        cyc(8'h02);
        wait_trig(8, 11, "R1 R2");
        repeat (4) cyc('0);

        // R5: zero start value, shortest path
        cyc(8'h01);
        wait_trig(3, 10, "R5");
        repeat (4) cyc('0);

        // R4 R11: sources 2 and 3 together; 2 first (S=2), 3 accepted after
        cyc(8'h0C);
        cyc('0);
        chk(ack[2] == 1'b1, "R4 winner acked", int'(ack[2]), 1);
        chk(ack[3] == 1'b0, "R11 loser not acked while busy", int'(ack[3]), 0);
        wait_trig(4, 12, "R4 first");
        wait_trig(12, 13, "R4 pending loser");
        repeat (4) cyc('0);

        // R9: both groups expire together, group 0 first, group 1 next cycle
        cyc(8'h11);
        wait_trig(3, 10, "R9 lower group");
        cyc('0);
        chk(trig == 1'b1, "R9 held group granted next", int'(trig), 1);
        chk(chan == 5'd14, "R9 held group channel", int'(chan), 14);
        cyc('0);
        chk(trig == 1'b0, "R6 single pulse", int'(trig), 0);
        repeat (4) cyc('0);

        // R7 R8: force bits
        cyc('0, 1, AW'(4 + 7), cfg_word(17, 3, 1));
        cyc('0, 1, AW'(4 + 6), cfg_word(16, 2, 1));
        cyc('0);
        chk(ack[7] == 1'b1, "R7 forced ack", int'(ack[7]), 1);
        chk(ack[6] == 1'b0, "R8 force ignored", int'(ack[6]), 0);
        repeat (3) cyc('0);
        chk(ack[7] == 1'b1, "R7 forced ack held", int'(ack[7]), 1);
        chk(ack[6] == 1'b0, "R8 force still ignored", int'(ack[6]), 0);
        cyc(8'h40);
        wait_trig(5, 16, "R8 normal service");
        cyc('0, 1, AW'(4 + 7), cfg_word(17, 3, 0));
        cyc('0, 1, AW'(4 + 6), cfg_word(16, 2, 0));
        repeat (4) cyc('0);

        // mixed traffic against the model
        for (int t = 0; t < 600; t++) begin
            logic [N-1:0] r;
            r = '0;
            if ($urandom_range(0, 5) == 0) r[$urandom_range(0, N-1)] = 1'b1;
            if ($urandom_range(0, 11) == 0) r[$urandom_range(0, N-1)] = 1'b1;
            cyc(r);
        end
        repeat (40) cyc('0);

        // R10: reset in the middle of a count
        cyc(8'h08);
        repeat (3) cyc('0);
        rst   = 1'b1;
        flags = '0;
        cyc('0);
        chk(ack == '0, "R10 ack after reset", int'(ack), 0);
        chk(trig == 1'b0, "R10 trigger after reset", int'(trig), 0);
        rst = 1'b0;
        seen = 0;
        for (int t = 0; t < 20; t++) begin
            cyc('0);
            if (trig) seen++;
        end
        chk(seen == 0, "R10 count discarded", seen, 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule